// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block is the receiving end of a three-wire serial setup port. A host drives a shift clock, a serial data line and a latch-enable line. While latch-enable is low, every rising edge of the shift clock pushes one data bit into a 32-bit shift register, most significant bit first. When latch-enable rises, the word in the shift register is split into a 4-bit register address (the low nibble) and a 28-bit payload. The payload is written into one of sixteen configuration registers.

All three serial lines are asynchronous to the system clock. They are first passed through synchronizer flops, and their edges are detected in the system clock domain. Two words carry special meaning. A word that targets register 0 with its top bit set is a soft reset: every register returns to its default value and the rest of that word is discarded. Any commit to register 15 raises a one-cycle calibration-start strobe. The full register bank is presented as a flat output bus for the logic that consumes the settings.

Top module: `cfg_serial_port`

## Requirements
- R1: A committed word's bits [3:0] choose the register and bits [31:4] become its 28-bit value. Register i appears at `bank_o[i*28 +: 28]`.
- R2: Bits enter the shift register on rising edges of `sclk_i` while `latch_i` is low. The first bit sent ends up as word bit 31.
- R3: The bank changes only after a rising edge of `latch_i`. Shifting bits in leaves every register as it was.
- R4: If register 0 is addressed and word bit 31 is 1, every register takes the value `DEFAULT_WORD`. The other 27 payload bits are discarded, and `soft_rst_o` is high for exactly one system clock cycle.
- R5: If register 0 is addressed and word bit 31 is 0, the payload is stored in register 0 like any other write, and `soft_rst_o` stays low.
- R6: A commit to register 15 produces exactly one single-cycle pulse on `cal_start_o`. A commit to any other address produces none.
- R7: While `rst_n` is low, every register holds `DEFAULT_WORD` and both strobes are low.
- R8: If more than 32 bits are shifted before a commit, only the last 32 bits take effect.
- R9: If fewer than 32 bits are shifted before a commit, the commit still takes place. It uses the earlier contents of the shift register, moved up by the number of new bits, with the new bits in the low positions.
- R10: Rising edges of `sclk_i` while `latch_i` is high have no effect on the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| latch_i | input | 1 | Latch enable: low while shifting, a rising edge commits (asynchronous) |
| bank_o | output | 448 | All sixteen 28-bit registers, register i at bits i*28 +: 28 |
| soft_rst_o | output | 1 | One-cycle strobe when a reset word is committed |
| cal_start_o | output | 1 | One-cycle strobe when register 15 is written |

## Verification
The bench builds the block with two synchronizer stages, so every serial-line edge takes three system clock cycles to act. It uses a non-zero `DEFAULT_WORD` (0x5A5A5A5). With a non-zero default, a reset that did nothing cannot be mistaken for one that cleared the registers, and a word written as zeros stays distinct from the default. Because the address width is kept at four, the top register is 15, so the calibration strobe and the reset-word decode are both checked at their true addresses.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 28,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] DEFAULT_WORD = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk_i,
  input  logic                            sdata_i,
  input  logic                            latch_i,
  output logic [(DATA_W<<ADDR_W)-1:0]     bank_o,
  output logic                            soft_rst_o,
  output logic                            cal_start_o
);
  localparam int WORD_W   = ADDR_W + DATA_W;
  localparam int NREG     = 1 << ADDR_W;
  localparam int RST_BIT  = DATA_W - 1;
  localparam int CAL_ADDR = NREG - 1;

  logic [SYNC_STAGES-1:0] sclk_sync, sdat_sync, lat_sync;
  logic sclk_prev, lat_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sdat_sync <= '0;
      lat_sync  <= '0;
      sclk_prev <= 1'b0;
      lat_prev  <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], sdata_i};
      lat_sync  <= {lat_sync[SYNC_STAGES-2:0], latch_i};
      sclk_prev <= sclk_sync[SYNC_STAGES-1];
      lat_prev  <= lat_sync[SYNC_STAGES-1];
    end
  end

  logic sclk_s, sdat_s, lat_s, sclk_rise, lat_rise;
  assign sclk_s    = sclk_sync[SYNC_STAGES-1];
  assign sdat_s    = sdat_sync[SYNC_STAGES-1];
  assign lat_s     = lat_sync[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_prev;
  assign lat_rise  = lat_s & ~lat_prev;

  logic [WORD_W-1:0] shift_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 shift_q <= '0;
    else if (sclk_rise && !lat_s) shift_q <= {shift_q[WORD_W-2:0], sdat_s};
  end

  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              rst_word;
  assign wr_addr  = shift_q[ADDR_W-1:0];
  assign wr_data  = shift_q[WORD_W-1:ADDR_W];
  assign rst_word = lat_rise && (wr_addr == '0) && wr_data[RST_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        reg_q <= DEFAULT_WORD;
      else if (rst_word)                                 reg_q <= DEFAULT_WORD;
      else if (lat_rise && wr_addr == ADDR_W'(g))        reg_q <= wr_data;
    end
    assign bank_o[g*DATA_W +: DATA_W] = reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_o  <= 1'b0;
      cal_start_o <= 1'b0;
    end else begin
      soft_rst_o  <= rst_word;
      cal_start_o <= lat_rise && (wr_addr == ADDR_W'(CAL_ADDR));
    end
  end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 28,
  parameter logic [DATA_W-1:0] DEFAULT_WORD = '0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sclk_rise,
  input logic                        lat_rise,
  input logic                        lat_s,
  input logic [ADDR_W+DATA_W-1:0]    shift_q,
  input logic [(DATA_W<<ADDR_W)-1:0] bank_o,
  input logic                        soft_rst_o,
  input logic                        cal_start_o
);
  localparam int NREG = 1 << ADDR_W;

  // R3
  bank_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_o) |-> $past(lat_rise));

  // R4
  soft_rst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> bank_o == {NREG{DEFAULT_WORD}});

  // R4
  soft_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R6
  cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |=> !cal_start_o);

  // R6
  cal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |-> $past(lat_rise) && ($past(shift_q[ADDR_W-1:0]) == ADDR_W'(NREG-1)));

  // R10
  shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shift_q) |-> $past(sclk_rise && !lat_s));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEFAULT_WORD(DEFAULT_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .lat_rise(lat_rise),
  .lat_s(lat_s), .shift_q(shift_q), .bank_o(bank_o),
  .soft_rst_o(soft_rst_o), .cal_start_o(cal_start_o)
);

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 28;
  localparam int NR = 1 << AW;
  localparam logic [DW-1:0] DEF = 28'h5A5A5A5;

  logic clk = 0, rst_n = 0, sclk = 0, sdata = 0, latch = 0;
  logic [(DW<<AW)-1:0] bank;
  logic soft_rst, cal_start;

  cfg_serial_port #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .DEFAULT_WORD(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .latch_i(latch),
    .bank_o(bank), .soft_rst_o(soft_rst), .cal_start_o(cal_start));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int soft_cnt = 0, cal_cnt = 0;
  logic [DW-1:0] exp_reg [NR];
  logic [31:0] sr_m = '0;

  always @(posedge clk) begin
    if (soft_rst) soft_cnt++;
    if (cal_start) cal_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++)
      check(bank[i*DW +: DW] == exp_reg[i], req, bank[i*DW +: DW], exp_reg[i]);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b; wait_clk(4);
    sclk = 1;  wait_clk(4);
    sclk = 0;  wait_clk(4);
    if (!latch) sr_m = {sr_m[30:0], b};
  endtask

  task automatic shift_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic commit();
    logic [3:0] a;
    logic [DW-1:0] d;
    a = sr_m[3:0]; d = sr_m[31:4];
    latch = 1; wait_clk(6);
    latch = 0; wait_clk(4);
    if (a == 0 && d[DW-1]) for (int i = 0; i < NR; i++) exp_reg[i] = DEF;
    else exp_reg[a] = d;
  endtask

  task automatic t_reset();
    // R7
    for (int i = 0; i < NR; i++) exp_reg[i] = DEF;
    check_bank("R7");
    check(soft_rst == 0 && cal_start == 0, "R7", {soft_rst, cal_start}, 0);
  endtask

  task automatic t_write(input logic [3:0] a, input logic [DW-1:0] d, input string req);
    soft_cnt = 0; cal_cnt = 0;
    shift_word({d, a});
    check_bank("R3");
    commit();
    check(bank[a*DW +: DW] == d, req, bank[a*DW +: DW], d);
    check_bank(req);
    check(cal_cnt == (a == 4'hF ? 1 : 0), "R6", cal_cnt, (a == 4'hF ? 1 : 0));
    check(soft_cnt == 0, "R5", soft_cnt, 0);
  endtask

  task automatic t_soft_reset();
    soft_cnt = 0; cal_cnt = 0;
    shift_word({1'b1, 27'h3C0FFEE, 4'h0});
    commit();
    check_bank("R4");
    check(soft_cnt == 1, "R4", soft_cnt, 1);
    check(cal_cnt == 0, "R6", cal_cnt, 0);
  endtask

  task automatic t_long();
    // R8: 8 junk bits precede the real word
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    shift_word({28'h1234567, 4'h9});
    commit();
    check(bank[9*DW +: DW] == 28'h1234567, "R8", bank[9*DW +: DW], 28'h1234567);
    check_bank("R8");
  endtask

  task automatic t_short();
    logic [31:0] w;
    shift_word({28'h00ABCDE, 4'h2});
    commit();
    // R9: eight more bits, then commit
    for (int i = 7; i >= 0; i--) shift_bit(8'hC3 >> i);
    w = {28'h00ABCDE, 4'h2} << 8 | 32'hC3;
    commit();
    check(bank[w[3:0]*DW +: DW] == w[31:4], "R9", bank[w[3:0]*DW +: DW], w[31:4]);
    check_bank("R9");
  endtask

  task automatic t_ignore_high();
    shift_word({28'h7777777, 4'h5});
    commit();
    latch = 1; wait_clk(4);
    for (int i = 0; i < 6; i++) shift_bit(1'b1);
    latch = 0; wait_clk(4);
    commit();
    // R10: recommit with the same word
    check(bank[5*DW +: DW] == 28'h7777777, "R10", bank[5*DW +: DW], 28'h7777777);
    check_bank("R10");
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1; wait_clk(3);
    t_reset();
    t_write(4'h3, 28'h8000001, "R1");
    t_write(4'h0, 28'h7FEDCBA, "R5");
    t_write(4'hF, 28'h0000000, "R6");
    t_write(4'h7, 28'hA5C3F01, "R2");
    t_soft_reset();
    t_long();
    t_short();
    t_ignore_high();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule